// File: doc/BRIEF.md
# Zero-Turnaround Synchronous Burst SRAM

This block is an on-chip static memory with a single-clock synchronous command port. Reads and writes can alternate on consecutive clock edges with no idle cycle between them. Address and command are registered on a rising edge. A read then drives its data in the same cycle, because there is no output register. A write takes its data and byte enables from the bus one edge later.

Because write data arrives one edge late, it sits in a one-entry pending buffer and reaches the array on the following edge. A read that targets the pending word is served from that buffer, lane by lane.

A two-bit burst counter steps through the four words of an aligned group. It can use either XOR (interleaved) or additive (linear) order. Three chip enables gate new commands, which allows depth expansion. An asynchronous output enable gates the bus drive. A sleep input freezes every register while it is high.

The data bus is a split bus: `dq_in`, `dq_out` and the drive enable `dq_drv`. These connect to one external tri-state pad buffer.

Top module: `nodead_sram`

## Requirements
- R1: While `rst` is high, and after it is released until a read command is registered, `dq_drv` is 0. Reset drops any registered command.
- R2: A read is selected when all chip enables are active and `adv_i`=0, `wr_i`=0. Its data is on `dq_out` with `dq_drv`=1 in the cycle that directly follows the edge that registered it.
- R3: A write command registered on edge N takes its data from `dq_in` and its lane enables from `bw_i` on edge N+1. `dq_drv` stays 0 for a write.
- R4: A read may directly follow a write, and a write may directly follow a read, with no idle edge. A read of the word whose write data was taken on the same edge returns the new data.
- R5: Byte lane l is bits [l*LANE_W +: LANE_W] of the data bus. It is written only when `bw_i[l]`=1, and lanes whose enable is 0 keep their old contents. The same per-lane choice applies when a read is served from the pending write.
- R6: With `lin_order_i`=0, the low two address bits of burst beat k are the start bits XOR k, for k = 0, 1, 2, 3. The upper bits stay fixed.
- R7: With `lin_order_i`=1, the low two address bits of beat k are (start + k) mod 4. The upper bits stay fixed.
- R8: A new command is accepted only when `cs_a_i`=1, `cs_b_i`=1 and `cs_n_i`=0. Otherwise the edge registers a deselect: nothing is driven and nothing is written.
- R9: `oe_n_i`=1 forces `dq_drv` to 0 at once, with no clock edge.
- R10: While `sleep_i`=1, `dq_drv` is 0 and commands are ignored. All registers, including a write still waiting for its data and a read in progress, hold their state. Operation resumes from that state once `sleep_i` returns to 0.
- R11: `adv_i`=1 moves an active burst to its next beat of the same kind. On such an edge the address, `wr_i` and chip enables are ignored. After a deselect, `adv_i` leaves the block deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge only |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | Freeze all state, release the bus |
| lin_order_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| cs_a_i | input | 1 | Chip enable, active high |
| cs_b_i | input | 1 | Chip enable, active high |
| cs_n_i | input | 1 | Chip enable, active low |
| adv_i | input | 1 | Advance the current burst |
| wr_i | input | 1 | 1 write, 0 read for a new command |
| addr_i | input | ADDR_W | Word address of a new command |
| bw_i | input | LANES | Lane write enables, taken with the data |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*LANE_W | Bus value seen at the pad |
| dq_out | output | LANES*LANE_W | Read data toward the pad |
| dq_drv | output | 1 | Pad drive enable |

## Verification
The edge that takes a write's data can also register a read of that same word. The read is then served from a buffer that was loaded on that very edge, while the array still holds the old word. The bench provokes this with write-then-read pairs to the same address, once with both lanes enabled and once with only the low lane. It judges the result per lane against a model of which lanes were just written. It also brings sleep into the cycle in which a write's data is due. It checks that the capture waits for the wake edge and that the word read straight after waking is the value held on the bus.

// File: rtl/nodead_pkg.sv
package nodead_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;

    // Low address bits of a burst beat: additive or XOR ordering.
    function automatic logic [BEAT_W-1:0] beat_lo(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input logic              linear
    );
        logic [BEAT_W-1:0] sum;
        sum = start + beat;
        return linear ? sum : (start ^ beat);
    endfunction

endpackage

// File: rtl/nodead_cmd.sv
module nodead_cmd
    import nodead_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              linear,
    input  logic              sel_ok,
    input  logic              adv,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              cmd_valid,
    output op_e               cmd_op,
    output logic [ADDR_W-1:0] cmd_addr
);

    logic              valid_q;
    op_e               op_q;
    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            op_q    <= OP_RD;
            base_q  <= '0;
            beat_q  <= '0;
        end else if (!hold) begin
            if (adv) begin
                if (valid_q) begin
                    beat_q <= beat_q + 1'b1;
                end
            end else if (sel_ok) begin
                valid_q <= 1'b1;
                op_q    <= wr ? OP_WR : OP_RD;
                base_q  <= addr;
                beat_q  <= '0;
            end else begin
                valid_q <= 1'b0;
            end
        end
    end

    assign cmd_valid = valid_q;
    assign cmd_op    = op_q;
    assign cmd_addr  = {base_q[ADDR_W-1:BEAT_W], beat_lo(base_q[BEAT_W-1:0], beat_q, linear)};

    // R11: an advance keeps the base and steps the beat by one
    p_adv_step_r11: assert property (@(posedge clk) disable iff (rst)
        (!hold && adv && valid_q) |=>
            (valid_q && beat_q == $past(beat_q) + 2'd1 && base_q == $past(base_q)));

    // R8: a non-advance edge without full selection leaves no command
    p_deselect_r8: assert property (@(posedge clk) disable iff (rst)
        (!hold && !adv && !sel_ok) |=> !valid_q);

    // R10: command state frozen across a sleep edge
    p_sleep_hold_r10: assert property (@(posedge clk) disable iff (rst)
        hold |=> (valid_q == $past(valid_q) && beat_q == $past(beat_q)
                  && base_q == $past(base_q) && op_q == $past(op_q)));

endmodule

// File: rtl/nodead_wbuf.sv
module nodead_wbuf
    import nodead_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              cmd_valid,
    input  op_e               cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] din,
    input  logic [LANES-1:0]  lane_en,
    output logic              pend_valid,
    output logic [ADDR_W-1:0] pend_addr,
    output logic [DATA_W-1:0] pend_data,
    output logic [LANES-1:0]  pend_en,
    output logic              commit
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            pend_addr  <= '0;
            pend_data  <= '0;
            pend_en    <= '0;
        end else if (!hold) begin
            pend_valid <= cmd_valid && (cmd_op == OP_WR);
            pend_addr  <= cmd_addr;
            pend_data  <= din;
            pend_en    <= lane_en;
        end
    end

    // The buffered word reaches the array on the next awake edge.
    assign commit = pend_valid && !hold;

    // R3: data and lane enables are taken one edge after the write command
    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (!hold && cmd_valid && cmd_op == OP_WR) |=>
            (pend_valid && pend_addr == $past(cmd_addr)
             && pend_data == $past(din) && pend_en == $past(lane_en)));

endmodule

// File: rtl/nodead_array.sv
module nodead_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LANES-1:0]  we_lane,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    for (genvar l = 0; l < LANES; l++) begin : g_bank
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (we && we_lane[l]) begin
                bank[waddr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        assign rdata[l*LANE_W +: LANE_W] = bank[raddr];
    end

endmodule

// File: rtl/nodead_sram.sv
module nodead_sram
    import nodead_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_i,
    input  logic              lin_order_i,
    input  logic              cs_a_i,
    input  logic              cs_b_i,
    input  logic              cs_n_i,
    input  logic              adv_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LANES-1:0]  bw_i,
    input  logic              oe_n_i,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drv
);

    logic              sel_ok;
    logic              cmd_valid;
    op_e               cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic              pend_valid;
    logic [ADDR_W-1:0] pend_addr;
    logic [DATA_W-1:0] pend_data;
    logic [LANES-1:0]  pend_en;
    logic              commit;
    logic [DATA_W-1:0] arr_rdata;
    logic              addr_hit;

    assign sel_ok = cs_a_i && cs_b_i && !cs_n_i;

    nodead_cmd #(.ADDR_W(ADDR_W)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .hold      (sleep_i),
        .linear    (lin_order_i),
        .sel_ok    (sel_ok),
        .adv       (adv_i),
        .wr        (wr_i),
        .addr      (addr_i),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr)
    );

    nodead_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
        .clk        (clk),
        .rst        (rst),
        .hold       (sleep_i),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr),
        .din        (dq_in),
        .lane_en    (bw_i),
        .pend_valid (pend_valid),
        .pend_addr  (pend_addr),
        .pend_data  (pend_data),
        .pend_en    (pend_en),
        .commit     (commit)
    );

    nodead_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .we      (commit),
        .we_lane (pend_en),
        .waddr   (pend_addr),
        .wdata   (pend_data),
        .raddr   (cmd_addr),
        .rdata   (arr_rdata)
    );

    // Forward the word whose data was just taken, lane by lane.
    assign addr_hit = pend_valid && (pend_addr == cmd_addr);

    for (genvar l = 0; l < LANES; l++) begin : g_fwd
        assign dq_out[l*LANE_W +: LANE_W] = (addr_hit && pend_en[l])
            ? pend_data[l*LANE_W +: LANE_W]
            : arr_rdata[l*LANE_W +: LANE_W];
    end

    assign dq_drv = cmd_valid && (cmd_op == OP_RD) && !oe_n_i && !sleep_i;

    // R4: a read of a fully enabled pending word returns the buffered value
    p_bypass_full_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_RD && pend_valid && pend_addr == cmd_addr
         && pend_en == {LANES{1'b1}}) |-> (dq_out == pend_data));

endmodule

// File: tb/nodead_sram_bench.sv
module nodead_sram_bench;

    localparam int AW = 8;
    localparam int NL = 2;
    localparam int LW = 9;
    localparam int DW = NL * LW;
    localparam int NV = 24;

    typedef struct packed {
        logic          sel;
        logic          adv;
        logic          wr;
        logic [AW-1:0] addr;
        logic          drv;
        logic [NL-1:0] bw;
        logic [DW-1:0] wd;
        logic          exp_drv;
        logic [DW-1:0] exp_d;
        logic [3:0]    req;
    } vec_t;

    function automatic vec_t v(input logic sel, input logic adv, input logic wr,
                               input logic [AW-1:0] a, input logic drv,
                               input logic [NL-1:0] b, input logic [DW-1:0] wd,
                               input logic ed, input logic [DW-1:0] e,
                               input logic [3:0] rq);
        return '{sel, adv, wr, a, drv, b, wd, ed, e, rq};
    endfunction

    // One row per clock interval: command on the edge, bus during the cycle after it.
    localparam vec_t VECS [NV] = '{
        v(1,0,1,8'h10, 1,2'b11,18'h0A5A5, 0,18'h0,     4'd3),  // R3 write
        v(1,0,0,8'h10, 0,2'b00,18'h0,     1,18'h0A5A5, 4'd4),  // R4 read right after write
        v(1,0,1,8'h11, 1,2'b11,18'h12345, 0,18'h0,     4'd3),
        v(1,0,1,8'h11, 1,2'b01,18'h001FF, 0,18'h0,     4'd5),  // R5 low lane only
        v(1,0,0,8'h11, 0,2'b00,18'h0,     1,18'h123FF, 4'd5),  // R5 per-lane forward
        v(1,0,0,8'h10, 0,2'b00,18'h0,     1,18'h0A5A5, 4'd2),  // R2
        v(1,0,1,8'h12, 1,2'b11,18'h2AAAA, 0,18'h0,     4'd4),  // R4 write right after read
        v(1,0,0,8'h12, 0,2'b00,18'h0,     1,18'h2AAAA, 4'd4),
        v(0,0,0,8'h10, 0,2'b00,18'h0,     0,18'h0,     4'd8),  // R8 deselected read
        v(0,0,1,8'h10, 1,2'b11,18'h00000, 0,18'h0,     4'd8),  // R8 deselected write
        v(1,0,0,8'h10, 0,2'b00,18'h0,     1,18'h0A5A5, 4'd8),
        v(1,0,1,8'h21, 1,2'b11,18'h10101, 0,18'h0,     4'd6),  // R6 write burst 21,20,23,22
        v(0,1,0,8'h00, 1,2'b11,18'h20202, 0,18'h0,     4'd6),
        v(0,1,0,8'h00, 1,2'b11,18'h30303, 0,18'h0,     4'd6),
        v(0,1,0,8'h00, 1,2'b11,18'h01010, 0,18'h0,     4'd6),
        v(1,0,0,8'h20, 0,2'b00,18'h0,     1,18'h20202, 4'd6),
        v(1,0,0,8'h23, 0,2'b00,18'h0,     1,18'h30303, 4'd6),
        v(1,0,0,8'h22, 0,2'b00,18'h0,     1,18'h01010, 4'd6),  // R6 read burst 22,23,20,21
        v(1,1,1,8'hFF, 0,2'b00,18'h0,     1,18'h30303, 4'd11), // R11 advance ignores addr/wr
        v(1,1,0,8'h00, 0,2'b00,18'h0,     1,18'h20202, 4'd6),
        v(1,1,0,8'h00, 0,2'b00,18'h0,     1,18'h10101, 4'd6),
        v(1,1,0,8'h00, 0,2'b00,18'h0,     1,18'h01010, 4'd6),  // wrap
        v(0,0,0,8'h00, 0,2'b00,18'h0,     0,18'h0,     4'd8),
        v(1,1,0,8'h00, 0,2'b00,18'h0,     0,18'h0,     4'd11)  // R11 advance after deselect
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sleep_i = 1'b0;
    logic          lin_order_i = 1'b0;
    logic          cs_a_i = 1'b0;
    logic          cs_b_i = 1'b1;
    logic          cs_n_i = 1'b0;
    logic          adv_i = 1'b0;
    logic          wr_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [NL-1:0] bw_i = '0;
    logic          oe_n_i = 1'b0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_drv;

    int checks = 0;
    int failures = 0;

    // 4 time units per period: 250 MHz with a 1 ns unit
    always #2 clk = ~clk;

    nodead_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_nodead_sram (
        .clk         (clk),
        .rst         (rst),
        .sleep_i     (sleep_i),
        .lin_order_i (lin_order_i),
        .cs_a_i      (cs_a_i),
        .cs_b_i      (cs_b_i),
        .cs_n_i      (cs_n_i),
        .adv_i       (adv_i),
        .wr_i        (wr_i),
        .addr_i      (addr_i),
        .bw_i        (bw_i),
        .oe_n_i      (oe_n_i),
        .dq_in       (dq_in),
        .dq_out      (dq_out),
        .dq_drv      (dq_drv)
    );

    task automatic chk(input string tag, input logic ed, input logic [DW-1:0] e);
        checks++;
        if (dq_drv !== ed || (ed && dq_out !== e)) begin
            failures++;
            $display("FAIL %s: actual drv=%0b data=%h expected drv=%0b data=%h",
                     tag, dq_drv, dq_out, ed, e);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(input logic sel, input logic adv, input logic wr,
                        input logic [AW-1:0] a, input logic drv,
                        input logic [NL-1:0] b, input logic [DW-1:0] wd);
        cs_a_i = sel;
        adv_i  = adv;
        wr_i   = wr;
        addr_i = a;
        @(posedge clk);
        #1;
        dq_in = drv ? wd : '0;
        bw_i  = drv ? b : '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 during reset", 1'b0, '0);
        rst = 1'b0;
        step(0,0,0,8'h00, 0,2'b00,'0);
        chk("R1 after release", 1'b0, '0);

        for (int r = 0; r < NV; r++) begin
            step(VECS[r].sel, VECS[r].adv, VECS[r].wr, VECS[r].addr,
                 VECS[r].drv, VECS[r].bw, VECS[r].wd);
            chk($sformatf("R%0d row %0d", VECS[r].req, r), VECS[r].exp_drv, VECS[r].exp_d);
        end

        // R7 linear burst from 0x31: 31,32,33,30
        lin_order_i = 1'b1;
        step(1,0,1,8'h31, 1,2'b11,18'h11111);
        step(0,1,0,8'h00, 1,2'b11,18'h22222);
        step(0,1,0,8'h00, 1,2'b11,18'h33333);
        step(0,1,0,8'h00, 1,2'b11,18'h04444);
        step(1,0,0,8'h30, 0,2'b00,'0);
        chk("R7 beat3 at 0x30", 1'b1, 18'h04444);
        step(1,0,0,8'h32, 0,2'b00,'0);
        chk("R7 beat1 at 0x32", 1'b1, 18'h22222);
        lin_order_i = 1'b0;

        // R8 each chip enable alone blocks a read
        cs_n_i = 1'b1;
        step(1,0,0,8'h10, 0,2'b00,'0);
        chk("R8 cs_n high", 1'b0, '0);
        cs_n_i = 1'b0;
        cs_b_i = 1'b0;
        step(1,0,0,8'h10, 0,2'b00,'0);
        chk("R8 cs_b low", 1'b0, '0);
        cs_b_i = 1'b1;

        // R9 asynchronous output enable
        step(1,0,0,8'h10, 0,2'b00,'0);
        chk("R2 read before oe", 1'b1, 18'h0A5A5);
        oe_n_i = 1'b1;
        #1;
        chk("R9 oe off without edge", 1'b0, '0);
        oe_n_i = 1'b0;
        @(negedge clk);
        chk("R9 oe back on", 1'b1, 18'h0A5A5);

        // R10 write waiting for data across sleep
        step(1,0,1,8'h40, 1,2'b11,18'h15555);
        sleep_i = 1'b1;
        cs_a_i = 1'b1; wr_i = 1'b0; addr_i = 8'h10;
        #1;
        chk("R10 bus released in sleep", 1'b0, '0);
        repeat (2) @(negedge clk);
        sleep_i = 1'b0;
        step(1,0,0,8'h40, 0,2'b00,'0);
        chk("R10 data taken on wake edge", 1'b1, 18'h15555);
        step(1,0,0,8'h40, 0,2'b00,'0);
        chk("R10 word committed after wake", 1'b1, 18'h15555);

        // R10 read held across sleep, commands ignored
        step(1,0,0,8'h12, 0,2'b00,'0);
        chk("R2 read before sleep", 1'b1, 18'h2AAAA);
        sleep_i = 1'b1;
        wr_i = 1'b1; dq_in = 18'h3FFFF; bw_i = 2'b11;
        #1;
        chk("R10 read hidden in sleep", 1'b0, '0);
        repeat (2) @(negedge clk);
        sleep_i = 1'b0;
        #1;
        chk("R10 read resumes", 1'b1, 18'h2AAAA);
        cs_a_i = 1'b0; wr_i = 1'b0; dq_in = '0; bw_i = '0;
        @(negedge clk);
        step(1,0,0,8'h12, 0,2'b00,'0);
        chk("R10 sleep write ignored", 1'b1, 18'h2AAAA);

        // R1 reset drops a read in progress
        step(1,0,0,8'h10, 0,2'b00,'0);
        rst = 1'b1;
        cs_a_i = 1'b0;
        @(negedge clk);
        chk("R1 reset mid read", 1'b0, '0);
        rst = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog R1: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule